// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a queue of byte transfers by itself once software has set it up. Each of the 16 queue slots holds three bytes: a byte to send, a byte that was received, and a command byte. Software fills the slots and sets a first-slot pointer and a last-slot pointer. It then writes the start bit in the control register. The engine shifts every slot from the first pointer to the last, wrapping past the top slot. It stores each received byte, then sets a completion flag and raises an interrupt if the interrupt is enabled.

The serial clock runs at the system clock divided by twice a programmable divider. The mode register sets clock polarity and phase. An 8-bit one-hot register chooses which device select line is driven. Bit 7 of each slot's command byte decides whether the select line stays asserted after that slot. This lets multi-byte commands run under one select window. A single-bit lock flag is kept for software arbitration.

Registers are reached over a plain word-addressed bus: a write strobe with address and data, and a combinational read. The slot memories live in three address regions. The transmit byte of slot k is at transmit-region word 2k. The received byte of slot k is at receive-region word 2k+1.

Top module: `spiq_top`

## Requirements
- R1: After reset every select output is high, the serial clock is low, the interrupt is low, and the status, control, divider, pointer and select registers read 0.
- R2: While a queue runs, each serial clock half period lasts max(D, 8) system clocks, where D is the divider register at word 0x00.
- R3: Writing 1 to control bit 6 (word 0x02) while idle runs slots from the start pointer (word 0x04) to the end pointer (word 0x05) inclusive, wrapping from slot 15 to slot 0. Each slot sends the byte at word 0x20+2k, most significant bit first, in 8 clock pulses.
- R4: The byte received during slot k is stored in bits 7:0 of word 0x40+2k+1.
- R5: When bit 7 of slot k's command byte (word 0x60+k) is set and slot k is not the last slot, the select line stays asserted into the next slot. When the bit is clear, the select line is released for one half period between the slots.
- R6: When the last slot finishes, status bit 0 (word 0x03) is set and control bit 6 reads back 0. The interrupt output equals status bit 0 AND control bit 5. Writing 0 to status bit 0 clears both.
- R7: Mode bits 1:0 (word 0x01) are phase (bit 0) and polarity (bit 1). Polarity sets the idle clock level. With phase 0, input is sampled on the leading edge. With phase 1, it is sampled on the trailing edge, and output changes on the other edge.
- R8: The low 8 bits of word 0x07 are a one-hot mask. Select output i goes low while the engine asserts the select and mask bit i is set.
- R9: If the last slot's command bit 7 and control bit 7 are both set, the select line stays asserted after the queue completes. Clearing control bit 7 while idle releases it.
- R10: Writes to the transmit and command regions while a queue runs are ignored, and the receive region cannot be written from the bus.
- R11: Word 0x06 reads back the index of the slot being transferred.
- R12: The lock flag (word 0x08 bit 0) and the word-length field (word 0x01 bits 7:2) read back what was written and do not change the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low device selects |
| irq | output | 1 | Queue-done interrupt |

## Verification
A corrupted edge counter or phase decision shows within one slot. The slave model captures a byte that differs from the one queued, and the byte read back from the receive region is shifted. A wrong slot pointer sends bytes in the wrong order, and this shows on the first mismatched slot. The current-pointer read also disagrees. A lost or held select state shows as a wrong count of select releases over the queue. It also shows as a select line still low, or already high, at the completion point, checked before the next command.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [6:0] A_DIV  = 7'h00;
  localparam logic [6:0] A_MODE = 7'h01;
  localparam logic [6:0] A_CTRL = 7'h02;
  localparam logic [6:0] A_STAT = 7'h03;
  localparam logic [6:0] A_SPTR = 7'h04;
  localparam logic [6:0] A_EPTR = 7'h05;
  localparam logic [6:0] A_CPTR = 7'h06;
  localparam logic [6:0] A_CSEL = 7'h07;
  localparam logic [6:0] A_LOCK = 7'h08;

  localparam logic [1:0] RGN_TX  = 2'b01;
  localparam logic [1:0] RGN_RX  = 2'b10;
  localparam logic [1:0] RGN_CMD = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP
  } eng_state_t;
endpackage

// File: rtl/spiq_clkgen.sv
module spiq_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_eff,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == div_eff - 1'b1);
    cnt_n = cnt_q;
    if (!run)      cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R2: the half period is at least 8 clocks, so ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
  import spiq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  end_ptr,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              cont,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              cmd_hold,
  input  logic              miso,
  output logic              busy,
  output logic [PTR_W-1:0]  slot,
  output logic              sck,
  output logic              mosi,
  output logic              cs_active,
  output logic              rx_we,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done_pulse
);
  localparam int EDGE_W = $clog2(2 * BYTE_W);

  eng_state_t        st_q, st_n;
  logic [PTR_W-1:0]  slot_n;
  logic [EDGE_W-1:0] edge_q, edge_n;
  logic              sck_n, csa_n, shift_ok;
  logic [BYTE_W-1:0] tx_q, tx_n, rx_q, rx_n;

  assign shift_ok = cpha ? (edge_q != '0) : (edge_q != '1);

  always_comb begin
    st_n       = st_q;
    slot_n     = slot;
    edge_n     = edge_q;
    sck_n      = sck;
    tx_n       = tx_q;
    rx_n       = rx_q;
    csa_n      = cs_active;
    rx_we      = 1'b0;
    done_pulse = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        sck_n = cpol;
        csa_n = cs_active & cont;
        if (go) begin
          st_n   = ST_LEAD;
          slot_n = start_ptr;
          csa_n  = 1'b1;
        end
      end
      ST_LEAD: begin
        tx_n  = tx_byte;
        sck_n = cpol;
        if (tick) begin
          st_n   = ST_SHIFT;
          edge_n = '0;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          sck_n = ~sck;
          if (edge_q[0] == cpha) rx_n = {rx_q[BYTE_W-2:0], miso};
          else if (shift_ok)     tx_n = {tx_q[BYTE_W-2:0], 1'b0};
          edge_n = edge_q + 1'b1;
          if (edge_q == '1) st_n = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          rx_we = 1'b1;
          if (slot == end_ptr) begin
            done_pulse = 1'b1;
            st_n       = ST_IDLE;
            csa_n      = cmd_hold & cont;
          end else begin
            slot_n = slot + 1'b1;
            csa_n  = cmd_hold;
            st_n   = cmd_hold ? ST_LEAD : ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          st_n  = ST_LEAD;
          csa_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      slot      <= '0;
      edge_q    <= '0;
      sck       <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      cs_active <= 1'b0;
    end else begin
      st_q      <= st_n;
      slot      <= slot_n;
      edge_q    <= edge_n;
      sck       <= sck_n;
      tx_q      <= tx_n;
      rx_q      <= rx_n;
      cs_active <= csa_n;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign mosi    = tx_q[BYTE_W-1];
  assign rx_data = rx_q;

  // R5: the select never moves while bits are being clocked
  p_cs_steady_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && $past(st_q == ST_SHIFT)) |-> $stable(cs_active));
  // R7: after 16 edges the clock is parked at its idle level
  p_sck_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIL) |-> (sck == cpol));
endmodule

// File: rtl/spiq_regs.sv
module spiq_regs
  import spiq_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int PTR_W   = 4,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 8,
  parameter int NCS     = 8,
  parameter int AW      = 7,
  parameter int DW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              done_pulse,
  input  logic [PTR_W-1:0]  eng_slot,
  input  logic              rx_we,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [DIV_W-1:0]  div_eff,
  output logic              cpol,
  output logic              cpha,
  output logic              cont,
  output logic              go,
  output logic [PTR_W-1:0]  start_ptr,
  output logic [PTR_W-1:0]  end_ptr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              cmd_hold,
  output logic [NCS-1:0]    cs_sel,
  output logic              irq
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);

  logic [DIV_W-1:0] div_q, div_n;
  logic [7:0]       mode_q, mode_n;
  logic             start_q, start_n, ie_q, ie_n, cont_q, cont_n;
  logic             done_q, done_n, lock_q, lock_n;
  logic [PTR_W-1:0] sptr_q, sptr_n, eptr_q, eptr_n;
  logic [NCS-1:0]   csel_q, csel_n;
  logic [SLOTS-1:0][BYTE_W-1:0] tx_mem, tx_mem_n, rx_mem, rx_mem_n;
  logic [SLOTS-1:0][BYTE_W-1:0] cmd_mem, cmd_mem_n;

  logic [1:0] rgn;
  logic [3:0] widx;
  logic       slot_ok;

  assign rgn     = bus_addr[AW-1:AW-2];
  assign widx    = bus_addr[4:1];
  assign slot_ok = int'(widx) < SLOTS;
  assign go      = bus_we && (bus_addr == A_CTRL) && bus_wdata[6] && !busy;

  always_comb begin
    div_n = div_q;  mode_n = mode_q;  start_n = start_q; ie_n = ie_q;
    cont_n = cont_q; done_n = done_q; lock_n = lock_q;
    sptr_n = sptr_q; eptr_n = eptr_q; csel_n = csel_q;
    tx_mem_n = tx_mem; rx_mem_n = rx_mem; cmd_mem_n = cmd_mem;
    if (bus_we) begin
      if (bus_addr == A_DIV)  div_n  = bus_wdata[DIV_W-1:0];
      if (bus_addr == A_MODE) mode_n = bus_wdata[7:0];
      if (bus_addr == A_CTRL) begin
        cont_n = bus_wdata[7];
        ie_n   = bus_wdata[5];
        if (go) start_n = 1'b1;
      end
      if (bus_addr == A_STAT && !bus_wdata[0]) done_n = 1'b0;
      if (bus_addr == A_SPTR) sptr_n = bus_wdata[PTR_W-1:0];
      if (bus_addr == A_EPTR) eptr_n = bus_wdata[PTR_W-1:0];
      if (bus_addr == A_CSEL) csel_n = bus_wdata[NCS-1:0];
      if (bus_addr == A_LOCK) lock_n = bus_wdata[0];
      if (!busy && slot_ok && rgn == RGN_TX && !bus_addr[0])
        tx_mem_n[widx[PTR_W-1:0]] = bus_wdata[BYTE_W-1:0];
      if (!busy && rgn == RGN_CMD && !bus_addr[4] && int'(bus_addr[3:0]) < SLOTS)
        cmd_mem_n[bus_addr[PTR_W-1:0]] = bus_wdata[BYTE_W-1:0];
    end
    if (rx_we) rx_mem_n[eng_slot] = rx_data;
    if (done_pulse) begin
      done_n  = 1'b1;
      start_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; mode_q <= '0; start_q <= 1'b0; ie_q <= 1'b0;
      cont_q <= 1'b0; done_q <= 1'b0; lock_q <= 1'b0;
      sptr_q <= '0; eptr_q <= '0; csel_q <= '0;
      tx_mem <= '0; rx_mem <= '0; cmd_mem <= '0;
    end else begin
      div_q <= div_n; mode_q <= mode_n; start_q <= start_n; ie_q <= ie_n;
      cont_q <= cont_n; done_q <= done_n; lock_q <= lock_n;
      sptr_q <= sptr_n; eptr_q <= eptr_n; csel_q <= csel_n;
      tx_mem <= tx_mem_n; rx_mem <= rx_mem_n; cmd_mem <= cmd_mem_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_DIV)  bus_rdata = DW'(div_q);
    else if (bus_addr == A_MODE) bus_rdata = DW'(mode_q);
    else if (bus_addr == A_CTRL) bus_rdata = DW'({cont_q, start_q, ie_q, 5'b0});
    else if (bus_addr == A_STAT) bus_rdata = DW'(done_q);
    else if (bus_addr == A_SPTR) bus_rdata = DW'(sptr_q);
    else if (bus_addr == A_EPTR) bus_rdata = DW'(eptr_q);
    else if (bus_addr == A_CPTR) bus_rdata = DW'(eng_slot);
    else if (bus_addr == A_CSEL) bus_rdata = DW'(csel_q);
    else if (bus_addr == A_LOCK) bus_rdata = DW'(lock_q);
    else if (slot_ok && rgn == RGN_TX && !bus_addr[0])
      bus_rdata = DW'(tx_mem[widx[PTR_W-1:0]]);
    else if (slot_ok && rgn == RGN_RX && bus_addr[0])
      bus_rdata = DW'(rx_mem[widx[PTR_W-1:0]]);
    else if (rgn == RGN_CMD && !bus_addr[4] && int'(bus_addr[3:0]) < SLOTS)
      bus_rdata = DW'(cmd_mem[bus_addr[PTR_W-1:0]]);
  end

  assign div_eff   = (div_q < DIV_FLOOR) ? DIV_FLOOR : div_q;
  assign cpha      = mode_q[0];
  assign cpol      = mode_q[1];
  assign cont      = cont_q;
  assign start_ptr = sptr_q;
  assign end_ptr   = eptr_q;
  assign tx_byte   = tx_mem[eng_slot];
  assign cmd_hold  = cmd_mem[eng_slot][7];
  assign cs_sel    = csel_q;
  assign irq       = done_q & ie_q;

  // R6: the start bit drops once the queue reports completion
  p_start_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !start_q);
  // R10: slot contents are frozen while the engine stays busy
  p_tx_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tx_mem));
  p_cmd_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_mem));
endmodule

// File: rtl/spiq_top.sv
module spiq_top
  import spiq_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 8,
  parameter int NCS     = 8,
  parameter int AW      = 7,
  parameter int DW      = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n,
  output logic           irq
);
  localparam int PTR_W = $clog2(SLOTS);

  logic              busy, done_pulse, rx_we, go, tick;
  logic              cpol, cpha, cont, cmd_hold, cs_active;
  logic [PTR_W-1:0]  slot, start_ptr, end_ptr;
  logic [BYTE_W-1:0] rx_data, tx_byte;
  logic [DIV_W-1:0]  div_eff;
  logic [NCS-1:0]    cs_sel;

  spiq_regs #(
    .SLOTS(SLOTS), .PTR_W(PTR_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN),
    .NCS(NCS), .AW(AW), .DW(DW)
  ) u_regs (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .done_pulse, .eng_slot(slot), .rx_we, .rx_data,
    .div_eff, .cpol, .cpha, .cont, .go, .start_ptr, .end_ptr,
    .tx_byte, .cmd_hold, .cs_sel, .irq
  );

  spiq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk, .rst_n, .run(busy), .div_eff, .tick
  );

  spiq_engine #(.PTR_W(PTR_W)) u_engine (
    .clk, .rst_n, .go, .tick, .start_ptr, .end_ptr, .cpol, .cpha, .cont,
    .tx_byte, .cmd_hold, .miso(spi_miso), .busy, .slot, .sck(spi_sck),
    .mosi(spi_mosi), .cs_active, .rx_we, .rx_data, .done_pulse
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign spi_cs_n[i] = ~(cs_sel[i] & cs_active);
  end
endmodule

// File: tb/spiq_top_bench.sv
module spiq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_mosi;
  logic       miso_r = 1'b0;
  logic [7:0] spi_cs_n;
  logic       irq;

  int checks = 0;
  int errors = 0;

  spiq_top u_spiq_top (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .spi_sck, .spi_mosi, .spi_miso(miso_r), .spi_cs_n, .irq
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model and scoreboard
  logic       t_cpol = 1'b0, t_cpha = 1'b0;
  logic [7:0] resp [8];
  logic [7:0] cap = '0;
  logic [7:0] exp_q [$];
  int         edge_n = 0, byte_idx = 0, releases = 0;
  logic       sel_active;
  assign sel_active = (spi_cs_n != 8'hFF);

  task automatic expect_byte(logic [7:0] b);
    exp_q.push_back(b);
  endtask

  always @(posedge sel_active) begin
    edge_n = 0;
    if (!t_cpha) miso_r = resp[byte_idx % 8][7];
  end

  always @(negedge sel_active) releases++;

  always @(spi_sck) begin
    if (sel_active) begin
      int n;
      n = edge_n % 16;
      if ((n % 2) == int'(t_cpha)) cap = {cap[6:0], spi_mosi};
      else if (!t_cpha) begin
        if (n != 15) miso_r = resp[byte_idx % 8][7 - (n + 1) / 2];
        else         miso_r = resp[(byte_idx + 1) % 8][7];
      end else miso_r = resp[byte_idx % 8][7 - n / 2];
      edge_n++;
      if (n == 15) begin
        if (exp_q.size() == 0) chk("R3 unexpected byte", cap, 32'hFFFF);
        else chk("R3 mosi byte", cap, exp_q.pop_front());
        byte_idx++;
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (irq !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 irq raised", irq, 1);
  endtask

  task automatic new_run(logic cp, logic ch);
    t_cpol = cp; t_cpha = ch; byte_idx = 0; releases = 0;
  endtask

  initial begin
    logic [7:0] d;
    realtime t1, t2;
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", spi_cs_n, 8'hFF);
    chk("R1 sck", spi_sck, 0);
    chk("R1 irq", irq, 0);
    rd(7'h03, d); chk("R1 status", d, 0);
    rd(7'h02, d); chk("R1 ctrl", d, 0);
    rd(7'h07, d); chk("R1 csel", d, 0);
    rd(7'h00, d); chk("R1 div", d, 0);

    // Run A: mode 0, divider 3 clamps to 8, slots 0..2, hold, hold, release
    new_run(0, 0);
    resp[0] = 8'h3C; resp[1] = 8'hA1; resp[2] = 8'h7E;
    wr(7'h00, 8'd3); wr(7'h01, 8'h00); wr(7'h07, 8'h01);
    wr(7'h20, 8'hA5); wr(7'h22, 8'h0F); wr(7'h24, 8'hD2);
    wr(7'h60, 8'h80); wr(7'h61, 8'h80); wr(7'h62, 8'h00);
    wr(7'h04, 8'd0); wr(7'h05, 8'd2);
    expect_byte(8'hA5); expect_byte(8'h0F); expect_byte(8'hD2);
    wr(7'h02, 8'h60);
    @(spi_sck); t1 = $realtime;
    @(spi_sck); t2 = $realtime;
    chk("R2 half period clamped", int'((t2 - t1) / 10.0), 8);
    wait_irq();
    chk("R5 one release over held slots", releases, 1);
    chk("R8 cs released at end", spi_cs_n, 8'hFF);
    rd(7'h03, d); chk("R6 done set", d, 1);
    rd(7'h02, d); chk("R6 start self-cleared", d[6], 0);
    rd(7'h41, d); chk("R4 rx slot0", d, 8'h3C);
    rd(7'h43, d); chk("R4 rx slot1", d, 8'hA1);
    rd(7'h45, d); chk("R4 rx slot2", d, 8'h7E);
    wr(7'h43, 8'h00);
    rd(7'h43, d); chk("R10 rx region read-only", d, 8'hA1);
    wr(7'h03, 8'h00);
    @(negedge clk);
    chk("R6 irq cleared", irq, 0);
    rd(7'h03, d); chk("R6 done cleared", d, 0);

    // Run B: mode 3, divider 10, wrap 14..1, no holds, device 2
    new_run(1, 1);
    resp[0] = 8'h11; resp[1] = 8'h80; resp[2] = 8'h01; resp[3] = 8'hEE;
    wr(7'h00, 8'd10); wr(7'h01, 8'h03); wr(7'h07, 8'h04);
    @(negedge clk);
    chk("R7 idle clock high", spi_sck, 1);
    wr(7'h3C, 8'h96); wr(7'h3E, 8'h69); wr(7'h20, 8'hC3); wr(7'h22, 8'h18);
    wr(7'h6E, 8'h00); wr(7'h6F, 8'h00); wr(7'h60, 8'h00); wr(7'h61, 8'h00);
    wr(7'h04, 8'd14); wr(7'h05, 8'd1);
    expect_byte(8'h96); expect_byte(8'h69); expect_byte(8'hC3); expect_byte(8'h18);
    wr(7'h02, 8'h20 | 8'h40);
    rd(7'h06, d); chk("R11 current slot", d, 14);
    chk("R8 one-hot select", spi_cs_n, 8'hFB);
    wr(7'h20, 8'h00);
    wr(7'h60, 8'h80);
    @(spi_sck); t1 = $realtime;
    @(spi_sck); t2 = $realtime;
    chk("R2 half period", int'((t2 - t1) / 10.0), 10);
    wait_irq();
    chk("R5 release after every slot", releases, 4);
    rd(7'h20, d); chk("R10 tx write ignored", d, 8'hC3);
    rd(7'h60, d); chk("R10 cmd write ignored", d, 8'h00);
    rd(7'h5D, d); chk("R4 rx slot14", d, 8'h11);
    rd(7'h43, d); chk("R4 rx slot1", d, 8'hEE);
    wr(7'h03, 8'h00);

    // Runs C/D: modes 1 and 2 on slot 5
    for (int m = 1; m <= 2; m++) begin
      new_run(m[1], m[0]);
      resp[0] = 8'h96;
      wr(7'h01, 8'(m)); wr(7'h07, 8'h01);
      wr(7'h2A, 8'h5A); wr(7'h65, 8'h00);
      wr(7'h04, 8'd5); wr(7'h05, 8'd5);
      expect_byte(8'h5A);
      wr(7'h02, 8'h60);
      wait_irq();
      rd(7'h4B, d); chk("R7 rx in mode", d, 8'h96);
      chk("R7 clock parks at polarity", spi_sck, m[1]);
      wr(7'h03, 8'h00);
    end

    // Run E: final-slot hold with continue bit
    new_run(0, 0);
    resp[0] = 8'h42;
    wr(7'h01, 8'h00); wr(7'h07, 8'h02);
    wr(7'h26, 8'h81); wr(7'h63, 8'h80);
    wr(7'h04, 8'd3); wr(7'h05, 8'd3);
    expect_byte(8'h81);
    wr(7'h02, 8'hE0);
    wait_irq();
    repeat (4) @(negedge clk);
    chk("R9 select held after queue", spi_cs_n, 8'hFD);
    wr(7'h02, 8'h20);
    repeat (2) @(negedge clk);
    chk("R9 select released", spi_cs_n, 8'hFF);
    wr(7'h03, 8'h00);

    // R12: lock flag and word-length field
    wr(7'h08, 8'h01);
    rd(7'h08, d); chk("R12 lock set", d, 1);
    wr(7'h01, 8'h20);
    rd(7'h01, d); chk("R12 word-length field", d, 8'h20);
    wr(7'h08, 8'h00);
    rd(7'h08, d); chk("R12 lock cleared", d, 0);
    chk("R12 no transfer started", spi_cs_n, 8'hFF);

    chk("R3 all queued bytes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule